// File: doc/BRIEF.md
# Saturating Signed Arithmetic and Halfword Multiply-Accumulate Unit

This unit performs one signed 32-bit arithmetic operation per accepted input: an add or a subtract that clamps to the signed 32-bit limits instead of wrapping, a signed 16×16 multiply of halfwords chosen independently from each multiplicand, or that same product added to a 32-bit accumulator operand. Each result is registered and appears one clock after the input is presented with its valid strobe.

Any clamping event, and any signed 32-bit overflow in the accumulate step, sets a sticky overflow flag. The flag stays set across later operations, including ones that do not overflow. It returns to zero only when the dedicated clear input is asserted. The accumulate operation does not clamp. It returns the wrapped sum and reports the overflow only through the flag. A datapath or DSP pipeline stage uses the unit and polls the flag once after a run of operations.

Top module: `dsp_satmac`

## Requirements
- R1: For `in_op`=2'b00 (add), when the signed sum of `in_a` and `in_b` exceeds 0x7FFFFFFF, the result is 0x7FFFFFFF.
- R2: For the add or subtract, when the exact signed result is below -2^31, the result is 0x80000000.
- R3: For the add (2'b00) and subtract (2'b01, `in_a` minus `in_b`), a result inside the signed 32-bit range is returned exactly.
- R4: For `in_op`=2'b01 (subtract), when the exact difference exceeds 0x7FFFFFFF, the result is 0x7FFFFFFF.
- R5: For `in_op` 2'b10 and 2'b11, `sel_a_hi`=1 picks bits [31:16] of `in_a` and 0 picks bits [15:0`]; `sel_b_hi` does the same for `in_b`. Each picked halfword is a signed 16-bit value.
- R6: For `in_op`=2'b10 (multiply), the result is the signed 32-bit product of the two picked halfwords. This includes 0x8000×0x8000 = 0x40000000, and the flag is not set.
- R7: For `in_op`=2'b11 (multiply-accumulate), the result is the product plus `in_acc` modulo 2^32. The flag is set when that sum overflows the signed 32-bit range.
- R8: Once set, `q_flag` stays 1 through later operations that do not overflow.
- R9: `q_clear` drives `q_flag` to 0 on the next cycle, even when an overflowing operation is accepted in the same cycle.
- R10: `out_valid` is 1 exactly in the cycle after `in_valid` is 1. The result and the flag for an operation accepted at one edge are visible after that edge.
- R11: After reset, `out_valid`, `q_flag` and `out_result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted at this edge |
| in_op | input | 2 | 00 add, 01 subtract, 10 multiply, 11 multiply-accumulate |
| in_a | input | 32 | First operand / first multiplicand word |
| in_b | input | 32 | Second operand / second multiplicand word |
| in_acc | input | 32 | Accumulator operand for multiply-accumulate |
| sel_a_hi | input | 1 | Use upper halfword of in_a |
| sel_b_hi | input | 1 | Use upper halfword of in_b |
| q_clear | input | 1 | Clear the sticky overflow flag |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Registered result |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
Two flag events can fall in the same cycle: a clear of the sticky flag and a flag set by an overflowing operation. The bench provokes this by asserting `q_clear` together with a clamping subtract, once while the flag is already set. It expects the clamped result to appear while `q_flag` reads 0. The bench also checks a clear given in a cycle with no operation accepted, and confirms that a set arriving after a clear is still recorded.

// File: rtl/dsp_satmac_pkg.sv
package dsp_satmac_pkg;

  typedef enum logic [1:0] {
    OP_QADD = 2'b00,
    OP_QSUB = 2'b01,
    OP_SMUL = 2'b10,
    OP_SMLA = 2'b11
  } mac_op_e;

endpackage

// File: rtl/dsp_half_pick.sv
module dsp_half_pick #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0]   word_i,
  input  logic                upper_i,
  output logic [WORD_W/2-1:0] half_o
);
  localparam int unsigned HALF_W = WORD_W / 2;

  always_comb begin
    if (upper_i) begin
      half_o = word_i[WORD_W-1:HALF_W];
    end else begin
      half_o = word_i[HALF_W-1:0];
    end
  end
endmodule

// File: rtl/dsp_sat_addsub.sv
module dsp_sat_addsub #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              sub_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              clamp_o
);
  localparam logic [WORD_W-1:0] POS_LIM = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] NEG_LIM = {1'b1, {(WORD_W-1){1'b0}}};

  logic [WORD_W:0] a_ext;
  logic [WORD_W:0] b_ext;
  logic [WORD_W:0] wide;

  always_comb begin
    a_ext = {a_i[WORD_W-1], a_i};
    b_ext = {b_i[WORD_W-1], b_i};
    if (sub_i) begin
      wide = a_ext - b_ext;
    end else begin
      wide = a_ext + b_ext;
    end
    clamp_o = wide[WORD_W] ^ wide[WORD_W-1];
    if (!clamp_o) begin
      sum_o = wide[WORD_W-1:0];
    end else if (wide[WORD_W]) begin
      sum_o = NEG_LIM;
    end else begin
      sum_o = POS_LIM;
    end
  end
endmodule

// File: rtl/dsp_mac_core.sv
module dsp_mac_core #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W/2-1:0] ha_i,
  input  logic [WORD_W/2-1:0] hb_i,
  input  logic [WORD_W-1:0]   acc_i,
  input  logic                accumulate_i,
  output logic [WORD_W-1:0]   res_o,
  output logic                ovf_o
);
  localparam int unsigned HALF_W = WORD_W / 2;

  logic signed [WORD_W-1:0] ha_x;
  logic signed [WORD_W-1:0] hb_x;
  logic signed [WORD_W-1:0] prod;
  logic [WORD_W:0]          wide;

  always_comb begin
    ha_x = {{HALF_W{ha_i[HALF_W-1]}}, ha_i};
    hb_x = {{HALF_W{hb_i[HALF_W-1]}}, hb_i};
    prod = ha_x * hb_x;
    wide = {prod[WORD_W-1], prod} + {acc_i[WORD_W-1], acc_i};
    if (accumulate_i) begin
      res_o = wide[WORD_W-1:0];
      ovf_o = wide[WORD_W] ^ wide[WORD_W-1];
    end else begin
      res_o = prod;
      ovf_o = 1'b0;
    end
  end
endmodule

// File: rtl/dsp_satmac.sv
module dsp_satmac #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_acc,
  input  logic              sel_a_hi,
  input  logic              sel_b_hi,
  input  logic              q_clear,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              q_flag
);
  import dsp_satmac_pkg::*;

  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned N_MUL  = 2;

  mac_op_e op;
  assign op = mac_op_e'(in_op);

  logic [N_MUL-1:0][DATA_W-1:0] mul_word;
  logic [N_MUL-1:0]             mul_upper;
  logic [N_MUL-1:0][HALF_W-1:0] mul_half;

  assign mul_word  = {in_b, in_a};
  assign mul_upper = {sel_b_hi, sel_a_hi};

  for (genvar g = 0; g < N_MUL; g++) begin : g_pick
    dsp_half_pick #(.WORD_W(DATA_W)) u_pick (
      .word_i (mul_word[g]),
      .upper_i(mul_upper[g]),
      .half_o (mul_half[g])
    );
  end

  logic [DATA_W-1:0] as_res;
  logic              as_clamp;
  logic [DATA_W-1:0] mc_res;
  logic              mc_ovf;

  dsp_sat_addsub #(.WORD_W(DATA_W)) u_addsub (
    .a_i    (in_a),
    .b_i    (in_b),
    .sub_i  (op == OP_QSUB),
    .sum_o  (as_res),
    .clamp_o(as_clamp)
  );

  dsp_mac_core #(.WORD_W(DATA_W)) u_mac (
    .ha_i        (mul_half[0]),
    .hb_i        (mul_half[1]),
    .acc_i       (in_acc),
    .accumulate_i(op == OP_SMLA),
    .res_o       (mc_res),
    .ovf_o       (mc_ovf)
  );

  logic [DATA_W-1:0] res_d, res_q;
  logic              ev_d;
  logic              q_d, q_q;
  logic              vld_q;

  always_comb begin
    if ((op == OP_QADD) || (op == OP_QSUB)) begin
      res_d = as_res;
      ev_d  = as_clamp;
    end else begin
      res_d = mc_res;
      ev_d  = mc_ovf;
    end
  end

  always_comb begin
    q_d = q_q;
    if (q_clear) begin
      q_d = 1'b0;
    end else if (in_valid && ev_d) begin
      q_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      q_q   <= 1'b0;
    end else begin
      vld_q <= in_valid;
      q_q   <= q_d;
      if (in_valid) begin
        res_q <= res_d;
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign q_flag     = q_q;
endmodule

// File: rtl/dsp_satmac_chk.sv
module dsp_satmac_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_op,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              q_clear,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              q_flag
);
  // R10
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9
  q_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_clear |=> !q_flag);

  // R8
  q_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_flag && !q_clear) |=> q_flag);

  // R1
  pos_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b00 && !in_a[DATA_W-1] && !in_b[DATA_W-1])
      |=> !out_result[DATA_W-1]);

  // R2
  neg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b00 && in_a[DATA_W-1] && in_b[DATA_W-1])
      |=> out_result[DATA_W-1]);

  // R7
  q_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_flag) |-> $past(in_valid));
endmodule

bind dsp_satmac dsp_satmac_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_a      (in_a),
  .in_b      (in_b),
  .q_clear   (q_clear),
  .out_valid (out_valid),
  .out_result(out_result),
  .q_flag    (q_flag)
);

// File: tb/sim_dsp_satmac.sv
module sim_dsp_satmac;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_op;
  logic [31:0] in_a, in_b, in_acc;
  logic        sel_a_hi, sel_b_hi, q_clear;
  logic        out_valid;
  logic [31:0] out_result;
  logic        q_flag;

  dsp_satmac u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
    .sel_a_hi(sel_a_hi), .sel_b_hi(sel_b_hi), .q_clear(q_clear),
    .out_valid(out_valid), .out_result(out_result), .q_flag(q_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [31:0] res;
    logic        q;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  logic model_q = 1'b0;
  bit   done = 1'b0;

  function automatic longint half_val(input logic [31:0] w, input logic hi);
    logic [15:0] h;
    h = hi ? w[31:16] : w[15:0];
    return longint'($signed(h));
  endfunction

  function automatic longint sval(input logic [31:0] w);
    return longint'($signed(w));
  endfunction

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] acc, input logic sa, input logic sb_hi,
                      input logic clr, input string tag);
    longint exact;
    longint p;
    logic [31:0] r;
    logic ev;
    exp_t e;
    @(negedge clk);
    ev = 1'b0;
    case (op)
      2'b00, 2'b01: begin
        exact = (op == 2'b00) ? sval(a) + sval(b) : sval(a) - sval(b);
        if (exact > 64'sd2147483647) begin r = 32'h7FFFFFFF; ev = 1'b1; end
        else if (exact < -64'sd2147483648) begin r = 32'h80000000; ev = 1'b1; end
        else r = exact[31:0];
      end
      2'b10: begin
        p = half_val(a, sa) * half_val(b, sb_hi);
        r = p[31:0];
      end
      default: begin
        p = half_val(a, sa) * half_val(b, sb_hi);
        exact = p + sval(acc);
        r = exact[31:0];
        ev = (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
      end
    endcase
    if (clr) model_q = 1'b0;
    else if (ev) model_q = 1'b1;
    e.res = r; e.q = model_q; e.tag = tag;
    sb.push_back(e);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_acc = acc;
    sel_a_hi = sa; sel_b_hi = sb_hi; q_clear = clr;
  endtask

  task automatic idle(input logic clr);
    @(negedge clk);
    if (clr) model_q = 1'b0;
    in_valid = 1'b0; q_clear = clr;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      n_chk++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R10: unexpected out_valid, result %h, expected no output", out_result);
      end else begin
        e = sb.pop_front();
        if (out_result !== e.res || q_flag !== e.q) begin
          n_fail++;
          $display("FAIL %s: result %h q %b, expected result %h q %b",
                   e.tag, out_result, q_flag, e.res, e.q);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = 2'b00; in_a = '0; in_b = '0; in_acc = '0;
    sel_a_hi = 1'b0; sel_b_hi = 1'b0; q_clear = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    n_chk++;
    if (out_valid !== 1'b0 || q_flag !== 1'b0 || out_result !== 32'h0) begin
      n_fail++;
      $display("FAIL R11: valid %b q %b result %h, expected 0 0 00000000",
               out_valid, q_flag, out_result);
    end
    rst_n = 1'b1;

    send(2'b00, 32'd5, 32'd7, 32'd0, 0, 0, 0, "R3 add exact");
    send(2'b00, 32'h7FFFFFFF, 32'd1, 32'd0, 0, 0, 0, "R1 add positive clamp");
    send(2'b00, 32'd2, 32'd3, 32'd0, 0, 0, 0, "R8 flag held");
    send(2'b00, 32'd9, 32'hFFFFFFFF, 32'd0, 0, 0, 1, "R9 clear with plain add");
    send(2'b00, 32'h80000000, 32'hFFFFFFFF, 32'd0, 0, 0, 0, "R2 add negative clamp");
    send(2'b01, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'd0, 0, 0, 1, "R9 clear beats set, R4 sub clamp");
    send(2'b01, 32'h80000000, 32'd1, 32'd0, 0, 0, 0, "R2 sub negative clamp");
    idle(1'b1);
    @(negedge clk);
    // R9 clear with no operation, R10 no output when idle
    n_chk++;
    if (q_flag !== 1'b0 || out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R9/R10: q %b valid %b, expected 0 0", q_flag, out_valid);
    end
    q_clear = 1'b0;
    send(2'b01, 32'd10, 32'd25, 32'd0, 0, 0, 0, "R3 sub exact");
    send(2'b10, 32'h0003FFFE, 32'h7FFF0005, 32'd0, 0, 0, 0, "R5 R6 lo x lo");
    send(2'b10, 32'h0003FFFE, 32'h7FFF0005, 32'd0, 1, 0, 0, "R5 R6 hi x lo");
    send(2'b10, 32'h0003FFFE, 32'h7FFF0005, 32'd0, 0, 1, 0, "R5 R6 lo x hi");
    send(2'b10, 32'h0003FFFE, 32'h7FFF0005, 32'd0, 1, 1, 0, "R5 R6 hi x hi");
    send(2'b10, 32'h80001234, 32'h55558000, 32'd0, 1, 0, 0, "R6 min x min");
    send(2'b11, 32'h00000064, 32'hFFFD0000, 32'd1000, 0, 1, 0, "R7 mac exact");
    send(2'b11, 32'h00008000, 32'h00008000, 32'h7FFFFFFF, 0, 0, 0, "R7 mac overflow wraps");
    send(2'b11, 32'h00000002, 32'h00000003, 32'h00000004, 0, 0, 0, "R8 flag held after mac");
    idle(1'b0);
    repeat (3) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R10: %0d results missing, expected 0", sb.size());
    end
    report();
  end
endmodule